// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block lets a clocked host read and write an external asynchronous static RAM of 512K sixteen-bit words. The RAM has two chip selects of opposite polarity (one active low, one active high), separate active-low output and write strobes, and one active-low enable per byte lane. The host asks for one access at a time. It gives a pulsed request with a 19-bit word address, 16-bit write data, a two-bit lane mask and a read/write flag. The controller then sequences the RAM pins in whole clock cycles and signals completion with a one-cycle ready pulse.

The wait counts come from the clock period and the RAM timing, which are parameters. Read data is sampled only after the access time has elapsed since the address and strobes settled. The write strobe stays low for the write pulse time, with the address, lane enables and data held steady around it. The data bus is split into an output value, an output enable and an input value, so the pads can be tied together outside the block. The controller drives the bus only while the write strobe is low. It places one extra fully deselected cycle between a read and a following write.

Top module: `sram_bytelane_ctrl`

## Requirements
- R1: After reset and whenever `host_idle` is high, the RAM is deselected (`mem_ce1_n`=1, `mem_ce2`=0), `mem_oe_n`=1, `mem_we_n`=1 and `mem_dq_oe`=0. `host_ready` and `host_rdata` are 0 after reset.
- R2: A read (`host_we`=0) accepted on edge A selects the RAM and drives `mem_oe_n`=0 with `mem_we_n`=1 from A. It also presents the address and `mem_byte_n` = inverted `host_be` (bit 0 is bits 7:0, bit 1 is bits 15:8). These are held for RD_CYC = ceil(ACCESS_PS/CLK_PS) cycles, which is 6 at the defaults. `mem_dq_i` is sampled on edge A+RD_CYC.
- R3: A read finishes with `host_ready` high in the cycle after edge A+RD_CYC. In that cycle `host_rdata` holds the sampled word, and each lane whose `host_be` bit was 0 reads as 0.
- R4: A write accepted on edge A (not after a read) runs as follows. First comes one setup cycle with the RAM selected, the address and lane enables presented, and `mem_we_n`=1. Next, `mem_we_n`=0 for WR_CYC = ceil(WE_PULSE_PS/CLK_PS) cycles, which is 5 at the defaults. Then comes one hold cycle with `mem_we_n`=1 and the address and selection unchanged. Finally `host_ready` pulses. Address, lane enables and `mem_dq_o` are stable while `mem_we_n` is low.
- R5: During a write, only the lanes whose `host_be` bit is 1 have a low `mem_byte_n` bit, so the RAM keeps the other byte of the word.
- R6: `mem_dq_oe` is high only while `mem_we_n` is low, and never while `mem_oe_n` is low. When it is high, `mem_dq_o` carries the write data.
- R7: A write whose previous accepted access was a read first spends one cycle fully deselected. It then enters the setup cycle of R4, so the write strobe falls one cycle later than in R4.
- R8: A request raised while `host_idle` is low is ignored. It produces no access and no ready pulse.
- R9: Every accepted access produces exactly one `host_ready` pulse, one cycle long. A write returns `host_rdata`=0.
- R10: An access with `host_be`=00 still runs its full sequence with both lane enables high. A read returns 0, and a write changes nothing in the RAM.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | One-cycle request pulse, taken only while `host_idle` is high |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 19 | Word address |
| host_wdata | input | 16 | Write data |
| host_be | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8, 1 = enabled |
| host_idle | output | 1 | Controller can accept a request |
| host_ready | output | 1 | One-cycle completion pulse |
| host_rdata | output | 16 | Read data, valid with `host_ready` |
| mem_addr | output | 19 | RAM address |
| mem_ce1_n | output | 1 | RAM select, active low |
| mem_ce2 | output | 1 | RAM select, active high |
| mem_oe_n | output | 1 | RAM output strobe, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_byte_n | output | 2 | Lane enables, active low, bit 0 = low byte |
| mem_dq_o | output | 16 | Data bus value driven by the controller |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_i | input | 16 | Data bus value seen at the pads |

## Verification
The bench's RAM model returns junk until the access time has passed since the address settled. It also puts junk on any lane it does not drive. A controller that samples one cycle early, or forgets to zero a disabled lane, therefore returns a wrong word. A write that follows a read is timed separately. Without the extra deselected cycle its strobe would fall one cycle early, and a bus driven during a read would be flagged as contention. Partial-lane writes, an all-lanes-off access and a request raised mid-access are read back afterwards. A design that touched the other byte, wrote with no lanes, or accepted the stray request would leave a changed word or an unexpected ready pulse.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_RD,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD
  } seq_state_e;

  // Whole cycles needed to cover a time in picoseconds, at least one.
  function automatic int wait_cycles(input int need_ps, input int clk_ps);
    int n;
    n = (need_ps + clk_ps - 1) / clk_ps;
    if (n < 1) n = 1;
    return n;
  endfunction

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/sram_byte_lane.sv
module sram_byte_lane #(
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [LANE_W-1:0] wdata_in,
  input  logic              lane_en,
  input  logic              rd_capture,
  input  logic              wr_finish,
  input  logic [LANE_W-1:0] dq_in,
  output logic [LANE_W-1:0] dq_out,
  output logic [LANE_W-1:0] rdata
);

  // Write data is latched at acceptance and held for the whole access.
  always_ff @(posedge clk) begin
    if (rst) begin
      dq_out <= '0;
    end else if (load) begin
      dq_out <= wdata_in;
    end
  end

  // Read capture: a disabled lane returns zero; a write clears the lane.
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_capture) begin
      rdata <= lane_en ? dq_in : '0;
    end else if (wr_finish) begin
      rdata <= '0;
    end
  end

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int LANES  = 2,
  parameter int CNT_W  = 3,
  parameter int RD_CYC = 6,
  parameter int WR_CYC = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [LANES-1:0]  host_be,
  input  logic              timer_expired,
  output logic              timer_load,
  output logic [CNT_W-1:0]  timer_val,
  output logic              accept,
  output logic              rd_capture,
  output logic              wr_finish,
  output logic [LANES-1:0]  be_q,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce1_n,
  output logic              mem_ce2,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [LANES-1:0]  mem_byte_n,
  output logic              mem_dq_oe,
  output logic              host_ready,
  output logic              host_idle
);

  localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WR_CYC - 1);

  seq_state_e state;
  logic       prev_rd;

  assign accept     = host_req && (state == ST_IDLE);
  assign timer_load = (accept && !host_we) || (state == ST_WSETUP);
  assign timer_val  = (state == ST_WSETUP) ? WR_LOAD : RD_LOAD;
  assign rd_capture = (state == ST_RD) && timer_expired;
  assign wr_finish  = (state == ST_WHOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      prev_rd    <= 1'b0;
      be_q       <= '0;
      mem_addr   <= '0;
      mem_ce1_n  <= 1'b1;
      mem_ce2    <= 1'b0;
      mem_oe_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_byte_n <= '1;
      mem_dq_oe  <= 1'b0;
      host_ready <= 1'b0;
      host_idle  <= 1'b1;
    end else begin
      host_ready <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (host_req) begin
            mem_addr   <= host_addr;
            be_q       <= host_be;
            mem_byte_n <= ~host_be;
            host_idle  <= 1'b0;
            if (!host_we) begin
              state     <= ST_RD;
              prev_rd   <= 1'b1;
              mem_ce1_n <= 1'b0;
              mem_ce2   <= 1'b1;
              mem_oe_n  <= 1'b0;
            end else if (prev_rd) begin
              state   <= ST_TURN;
              prev_rd <= 1'b0;
            end else begin
              state     <= ST_WSETUP;
              mem_ce1_n <= 1'b0;
              mem_ce2   <= 1'b1;
            end
          end
        end
        ST_TURN: begin
          state     <= ST_WSETUP;
          mem_ce1_n <= 1'b0;
          mem_ce2   <= 1'b1;
        end
        ST_WSETUP: begin
          state     <= ST_WPULSE;
          mem_we_n  <= 1'b0;
          mem_dq_oe <= 1'b1;
        end
        ST_WPULSE: begin
          if (timer_expired) begin
            state     <= ST_WHOLD;
            mem_we_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
          end
        end
        ST_WHOLD: begin
          state      <= ST_IDLE;
          mem_ce1_n  <= 1'b1;
          mem_ce2    <= 1'b0;
          mem_byte_n <= '1;
          host_ready <= 1'b1;
          host_idle  <= 1'b1;
        end
        ST_RD: begin
          if (timer_expired) begin
            state      <= ST_IDLE;
            mem_ce1_n  <= 1'b1;
            mem_ce2    <= 1'b0;
            mem_oe_n   <= 1'b1;
            mem_byte_n <= '1;
            host_ready <= 1'b1;
            host_idle  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sram_bytelane_ctrl.sv
module sram_bytelane_ctrl #(
  parameter int ADDR_W      = 19,
  parameter int DATA_W      = 16,
  parameter int CLK_PS      = 8000,
  parameter int ACCESS_PS   = 45000,
  parameter int WE_PULSE_PS = 35000,
  localparam int LANES      = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [LANES-1:0]  host_be,
  output logic              host_idle,
  output logic              host_ready,
  output logic [DATA_W-1:0] host_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce1_n,
  output logic              mem_ce2,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [LANES-1:0]  mem_byte_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int LANE_W = DATA_W / LANES;
  localparam int RD_CYC = sram_ctrl_pkg::wait_cycles(ACCESS_PS, CLK_PS);
  localparam int WR_CYC = sram_ctrl_pkg::wait_cycles(WE_PULSE_PS, CLK_PS);
  localparam int MAX_CYC = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
  localparam int CNT_W  = $clog2(MAX_CYC + 1);

  logic             timer_load;
  logic [CNT_W-1:0] timer_val;
  logic             timer_expired;
  logic             accept;
  logic             rd_capture;
  logic             wr_finish;
  logic [LANES-1:0] be_q;

  sram_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (timer_load),
    .load_val (timer_val),
    .expired  (timer_expired)
  );

  sram_seq_fsm #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES),
    .CNT_W  (CNT_W),
    .RD_CYC (RD_CYC),
    .WR_CYC (WR_CYC)
  ) u_seq (
    .clk           (clk),
    .rst           (rst),
    .host_req      (host_req),
    .host_we       (host_we),
    .host_addr     (host_addr),
    .host_be       (host_be),
    .timer_expired (timer_expired),
    .timer_load    (timer_load),
    .timer_val     (timer_val),
    .accept        (accept),
    .rd_capture    (rd_capture),
    .wr_finish     (wr_finish),
    .be_q          (be_q),
    .mem_addr      (mem_addr),
    .mem_ce1_n     (mem_ce1_n),
    .mem_ce2       (mem_ce2),
    .mem_oe_n      (mem_oe_n),
    .mem_we_n      (mem_we_n),
    .mem_byte_n    (mem_byte_n),
    .mem_dq_oe     (mem_dq_oe),
    .host_ready    (host_ready),
    .host_idle     (host_idle)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sram_byte_lane #(.LANE_W(LANE_W)) u_lane (
      .clk        (clk),
      .rst        (rst),
      .load       (accept),
      .wdata_in   (host_wdata[g*LANE_W +: LANE_W]),
      .lane_en    (be_q[g]),
      .rd_capture (rd_capture),
      .wr_finish  (wr_finish),
      .dq_in      (mem_dq_i[g*LANE_W +: LANE_W]),
      .dq_out     (mem_dq_o[g*LANE_W +: LANE_W]),
      .rdata      (host_rdata[g*LANE_W +: LANE_W])
    );
  end

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              host_idle,
  input logic              host_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce1_n,
  input logic              mem_ce2,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [LANES-1:0]  mem_byte_n,
  input logic [DATA_W-1:0] mem_dq_o,
  input logic              mem_dq_oe
);

  p_idle_pins_r1: assert property (@(posedge clk) disable iff (rst)
    host_idle |-> (mem_ce1_n && !mem_ce2 && mem_oe_n && mem_we_n && !mem_dq_oe));

  p_read_strobes_r2: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (mem_we_n && !mem_ce1_n && mem_ce2));

  p_write_selected_r4: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_ce1_n && mem_ce2));

  p_write_stable_r4: assert property (@(posedge clk) disable iff (rst)
    (!mem_we_n && $past(!mem_we_n)) |->
      ($stable(mem_addr) && $stable(mem_dq_o) && $stable(mem_byte_n)));

  p_write_hold_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> ($stable(mem_addr) && !mem_ce1_n && mem_ce2));

  p_drive_window_r6: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> (!mem_we_n && mem_oe_n));

  p_turnaround_r7: assert property (@(posedge clk) disable iff (rst)
    $past(!mem_oe_n, 3) |-> !mem_dq_oe);

  p_ready_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    host_ready |=> !host_ready);

  p_ready_idle_r9: assert property (@(posedge clk) disable iff (rst)
    host_ready |-> host_idle);

endmodule

bind sram_bytelane_ctrl sram_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .LANES  (LANES)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .host_idle  (host_idle),
  .host_ready (host_ready),
  .mem_addr   (mem_addr),
  .mem_ce1_n  (mem_ce1_n),
  .mem_ce2    (mem_ce2),
  .mem_oe_n   (mem_oe_n),
  .mem_we_n   (mem_we_n),
  .mem_byte_n (mem_byte_n),
  .mem_dq_o   (mem_dq_o),
  .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sram_bytelane_ctrl_tb.sv
module sram_bytelane_ctrl_tb;

  localparam int RD_WAIT = (45000 + 7999) / 8000;  // 6
  localparam int WR_WAIT = (35000 + 7999) / 8000;  // 5

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_req = 1'b0;
  logic        host_we = 1'b0;
  logic [18:0] host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [1:0]  host_be = '0;
  logic        host_idle, host_ready;
  logic [15:0] host_rdata;
  logic [18:0] mem_addr;
  logic        mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [1:0]  mem_byte_n;
  logic [15:0] mem_dq_o;
  logic [15:0] mem_dq_i = 16'hC3C3;

  int n_checks = 0;
  int n_fail = 0;

  logic [15:0] ref_mem   [bit [18:0]];
  logic [15:0] model_mem [bit [18:0]];
  logic [15:0] exp_q[$];
  string       tag_q[$];
  bit          last_was_read = 1'b0;

  always #4 clk = ~clk;

  sram_bytelane_ctrl u_dut (
    .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_be(host_be),
    .host_idle(host_idle), .host_ready(host_ready), .host_rdata(host_rdata),
    .mem_addr(mem_addr), .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_byte_n(mem_byte_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // Asynchronous RAM model: data valid only once the access time has elapsed.
  int          stable_ps = 0;
  bit          prev_rc = 1'b0;
  logic [18:0] prev_a = '0;
  always @(negedge clk) begin
    bit sel, rc;
    logic [15:0] w;
    sel = !mem_ce1_n && mem_ce2;
    if (sel && !mem_we_n) begin
      w = model_mem.exists(mem_addr) ? model_mem[mem_addr] : 16'h0;
      for (int l = 0; l < 2; l++)
        if (!mem_byte_n[l]) w[l*8 +: 8] = mem_dq_oe ? mem_dq_o[l*8 +: 8] : 8'hEE;
      model_mem[mem_addr] = w;
    end
    rc = sel && !mem_oe_n && mem_we_n && (mem_byte_n != 2'b11);
    if (rc && prev_rc && mem_addr == prev_a) stable_ps += 8000;
    else stable_ps = 8000;
    prev_rc = rc;
    prev_a  = mem_addr;
    w = model_mem.exists(mem_addr) ? model_mem[mem_addr] : 16'h0;
    for (int l = 0; l < 2; l++) begin
      if (rc && !mem_byte_n[l])
        mem_dq_i[l*8 +: 8] <= (stable_ps >= 45000) ? w[l*8 +: 8] : 8'h5A;
      else
        mem_dq_i[l*8 +: 8] <= 8'hC3;
    end
    if (!rst && mem_dq_oe && rc)
      check(1'b0, "R6", "bus contention with RAM output", 32'(mem_dq_oe), 32'h0);
  end

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && host_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8", "ready with no outstanding access", 32'(host_rdata), 32'h0);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(host_rdata == e, t, "returned data", 32'(host_rdata), 32'(e));
      end
    end
  end

  task automatic access(input bit wr, input logic [18:0] a, input logic [1:0] be,
                        input logic [15:0] d, input bit inject);
    int idx = 0, first_we = -1, n_we = 0, n_drv = 0, n_oe = 0, rdy = -1;
    bit bad_we = 0, bad_rd = 0, bad_drv = 0, hold_ok = 0, pre_ok = 0, prev_we_low = 0;
    bit turn = wr && last_was_read;
    logic [15:0] e, r;
    while (!host_idle) @(negedge clk);
    r = ref_mem.exists(a) ? ref_mem[a] : 16'h0;
    if (wr) begin
      for (int l = 0; l < 2; l++) if (be[l]) r[l*8 +: 8] = d[l*8 +: 8];
      ref_mem[a] = r;
      e = 16'h0;
    end else begin
      e = r;
      for (int l = 0; l < 2; l++) if (!be[l]) e[l*8 +: 8] = 8'h00;
    end
    exp_q.push_back(e);
    tag_q.push_back(wr ? "R9" : "R3");
    host_req = 1; host_we = wr; host_addr = a; host_be = be; host_wdata = d;
    @(negedge clk);
    host_req = 0;
    while (idx < 60) begin
      if (inject && idx == 3) host_req = 0;
      if (idx == 0) begin
        if (turn) pre_ok = mem_ce1_n && !mem_ce2 && mem_we_n && !mem_dq_oe;
        else if (wr) pre_ok = !mem_ce1_n && mem_ce2 && mem_we_n && !mem_dq_oe &&
                              mem_addr == a && mem_byte_n == ~be;
      end
      if (!mem_we_n) begin
        n_we++;
        if (first_we < 0) first_we = idx;
        if (mem_addr != a || mem_dq_o != d || mem_byte_n != ~be || !mem_dq_oe) bad_we = 1;
      end else if (prev_we_low) begin
        hold_ok = !mem_ce1_n && mem_ce2 && mem_addr == a && mem_byte_n == ~be;
      end
      prev_we_low = !mem_we_n;
      if (mem_dq_oe) begin
        n_drv++;
        if (mem_we_n || !mem_oe_n) bad_drv = 1;
      end
      if (!mem_oe_n) begin
        n_oe++;
        if (mem_addr != a || mem_byte_n != ~be || !mem_we_n || mem_ce1_n || !mem_ce2) bad_rd = 1;
      end
      if (host_ready) begin
        rdy = idx;
        break;
      end
      if (inject && idx == 2) begin
        host_req = 1; host_we = 1; host_addr = 19'h00AAA; host_be = 2'b11; host_wdata = 16'hDEAD;
      end
      @(negedge clk);
      idx++;
    end
    check(!bad_drv, "R6", "bus driven outside write strobe", 32'(bad_drv), 32'h0);
    if (wr) begin
      check(pre_ok, turn ? "R7" : "R4", "first cycle after acceptance", 32'(pre_ok), 32'h1);
      check(first_we == (turn ? 2 : 1), turn ? "R7" : "R4", "write strobe start",
            32'(first_we), 32'(turn ? 2 : 1));
      check(n_we == WR_WAIT, "R4", "write strobe length", 32'(n_we), 32'(WR_WAIT));
      check(n_drv == WR_WAIT, "R6", "drive cycles", 32'(n_drv), 32'(WR_WAIT));
      check(!bad_we, "R5", "address/lanes/data during strobe", 32'(bad_we), 32'h0);
      check(hold_ok, "R4", "hold cycle after strobe", 32'(hold_ok), 32'h1);
      check(n_oe == 0, "R4", "output strobe during write", 32'(n_oe), 32'h0);
      check(rdy == first_we + WR_WAIT + 1, "R9", "write ready cycle",
            32'(rdy), 32'(first_we + WR_WAIT + 1));
    end else begin
      check(n_oe == RD_WAIT, "R2", "read strobe length", 32'(n_oe), 32'(RD_WAIT));
      check(!bad_rd, "R2", "address/lanes/strobes during read", 32'(bad_rd), 32'h0);
      check(n_we == 0, "R2", "write strobe during read", 32'(n_we), 32'h0);
      check(rdy == RD_WAIT, "R3", "read ready cycle", 32'(rdy), 32'(RD_WAIT));
    end
    @(negedge clk);
    check(!host_ready, "R9", "ready longer than one cycle", 32'(host_ready), 32'h0);
    last_was_read = !wr;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "R9", "watchdog expired", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    logic [15:0] lf;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset/idle pin state
    check(mem_ce1_n && !mem_ce2, "R1", "deselected after reset", {30'h0, mem_ce1_n, mem_ce2}, 32'h2);
    check(mem_oe_n && mem_we_n, "R1", "strobes high after reset", {30'h0, mem_oe_n, mem_we_n}, 32'h3);
    check(!mem_dq_oe && host_idle, "R1", "no drive, idle", {30'h0, mem_dq_oe, host_idle}, 32'h1);
    check(!host_ready && host_rdata == 0, "R1", "ready/rdata after reset", 32'(host_rdata), 32'h0);

    // Full-word writes, including the top address, then reads
    access(1, 19'h00000, 2'b11, 16'h1234, 0);
    access(1, 19'h7FFFF, 2'b11, 16'hA55A, 0);
    access(1, 19'h12345, 2'b11, 16'hCAFE, 0);
    access(1, 19'h00AAA, 2'b11, 16'h0F0F, 0);
    access(0, 19'h7FFFF, 2'b11, 16'h0, 0);
    access(0, 19'h00000, 2'b11, 16'h0, 0);
    check(host_idle && mem_ce1_n && !mem_ce2, "R1", "idle between accesses",
          {30'h0, host_idle, mem_ce1_n}, 32'h3);

    // R7 turnaround + R5 partial writes
    access(1, 19'h12345, 2'b01, 16'hBEEF, 0);
    access(0, 19'h12345, 2'b11, 16'h0, 0);
    access(1, 19'h12345, 2'b10, 16'h7700, 0);
    access(0, 19'h12345, 2'b01, 16'h0, 0);
    access(0, 19'h12345, 2'b10, 16'h0, 0);

    // R10: no lanes enabled
    access(1, 19'h00000, 2'b00, 16'hFFFF, 0);
    access(0, 19'h00000, 2'b00, 16'h0, 0);
    access(0, 19'h00000, 2'b11, 16'h0, 0);

    // R8: request raised mid-access is ignored
    access(0, 19'h12345, 2'b11, 16'h0, 1);
    access(0, 19'h00AAA, 2'b11, 16'h0, 0);

    // Mixed traffic
    lf = 16'hACE1;
    for (int i = 0; i < 8; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      access(1, {3'b101, lf}, 2'b11, lf ^ 16'h3C3C, 0);
      access(1, {3'b101, lf}, lf[1:0], ~lf, 0);
      access(0, {3'b101, lf}, 2'b11, 16'h0, 0);
    end

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R9", "accesses without ready", 32'(exp_q.size()), 32'h0);
    finish_run();
  end

endmodule